// File: doc/BRIEF.md
# Decimal Mailbox Accumulator Processor

This block is a small stored-program machine whose storage and arithmetic are decimal throughout. Each of its 100 mailboxes (numbered 00 to 99) holds a three-digit BCD number. The number can be an instruction or a data value. A single three-digit register, the calculator, receives every arithmetic result.

The machine repeats two steps. In the fetch step it reads the mailbox named by a two-digit program counter. In the execute step it carries out that instruction. Every instruction has the same shape: the leading digit selects the operation and the two trailing digits name a mailbox.

The instruction set covers:
- decimal add and subtract, wrapping modulo 1000;
- store and load;
- an unconditional branch and two conditional branches;
- an input instruction that waits on a valid/ready handshake;
- an output instruction that pulses a one-cycle strobe;
- halt.

Programs are written into the mailboxes through a dedicated write port, normally while reset is held.

Top module: `bcd_mailbox_cpu`

## Requirements
- R1: While rst_n is low, and at its release: calc_out is 000, calc_neg is 0, and halted, in_ready and out_valid are all 0. The first instruction is fetched from mailbox 00.
- R2: An instruction word is three BCD digits.
  - Bits 11:8 hold the operation digit.
  - Bits 7:4 and 3:0 hold the tens and units of the mailbox number.
  - Each instruction takes one fetch cycle and then one execute cycle.
  - The program counter advances in decimal and wraps from 99 to 00.
- R3: Operation 1 adds the mailbox to the calculator digit by digit in BCD, modulo 1000 (for example, 998 + 007 gives 005).
- R4: Operation 2 subtracts the mailbox from the calculator in BCD, modulo 1000. A result below zero wraps to its ten's complement (for example, 005 − 007 gives 998).
- R5: Operation 3 writes the calculator into the mailbox, replacing the old word. Operation 5 replaces the calculator with the mailbox contents.
- R6: The update rule for calc_neg depends on the operation:
  - A subtract sets calc_neg to its final borrow.
  - A load (operation 5 or input) clears calc_neg.
  - An add clears calc_neg when it carries out of the hundreds digit, and otherwise leaves it unchanged.
- R7: The branch operations all load the program counter with the mailbox field:
  - Operation 6 always loads it.
  - Operation 7 loads it only when the calculator is 000.
  - Operation 8 loads it only when calc_neg is 0.
- R8: Word 901 raises in_ready during its execute cycle and holds it until a cycle with in_valid high. On that edge in_data enters the calculator, calc_neg clears, and fetching resumes.
- R9: Word 902 raises out_valid for exactly one cycle. calc_out always shows the calculator.
- R10: Word 000 halts the machine. After that, halted stays high and in_ready and out_valid stay low, and the calculator does not change until reset.
- R11: The following words have no effect beyond advancing to the next mailbox: operation digit 4, operation 0 with a nonzero mailbox field, and operation 9 with a mailbox field other than 01 or 02.
- R12: A clock edge with ld_we high writes ld_data into mailbox ld_addr (two BCD digits).
  - This works during reset and while the machine runs.
  - If a store targets the same mailbox on the same edge, the port's write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Mailbox write-port enable |
| ld_addr | input | 8 | Mailbox number, two BCD digits |
| ld_data | input | 12 | Word to write, three BCD digits |
| in_valid | input | 1 | Input value offered |
| in_data | input | 12 | Input value, three BCD digits |
| in_ready | output | 1 | Machine is waiting in an input instruction |
| out_valid | output | 1 | One-cycle output strobe |
| calc_out | output | 12 | Calculator contents, three BCD digits |
| calc_neg | output | 1 | Sticky negative flag |
| halted | output | 1 | Machine has stopped |

## Verification
A corrupted calculator digit or a wrong borrow appears on calc_out and calc_neg on the very next edge. A reference model comparing every cycle therefore catches it at once. A wrong program counter, a misdecoded operation or a misplaced store is visible only indirectly. It shows up when out_valid or in_ready arrives in the wrong cycle, or when halted rises early or late, usually within a few instructions. The test program is arranged so that every branch outcome, the 99-to-00 wrap and each store feed an output strobe soon afterwards.

// File: rtl/bcd_mailbox_cpu.sv
`timescale 1ns/1ps
module bcd_mailbox_cpu #(
  parameter int DIGITS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_we,
  input  logic [7:0]            ld_addr,
  input  logic [4*DIGITS-1:0]   ld_data,
  input  logic                  in_valid,
  input  logic [4*DIGITS-1:0]   in_data,
  output logic                  in_ready,
  output logic                  out_valid,
  output logic [4*DIGITS-1:0]   calc_out,
  output logic                  calc_neg,
  output logic                  halted
);
  localparam int W     = 4 * DIGITS;
  localparam int SLOTS = 100;
  localparam int AW    = $clog2(SLOTS);

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_HALT} state_t;

  state_t       st;
  logic [W-1:0] mem [0:SLOTS-1];
  logic [7:0]   pc;
  logic [W-1:0] ir, acc;
  logic         neg;

  function automatic logic [AW-1:0] slot(input logic [7:0] d);
    return AW'(d[7:4]) * AW'(10) + AW'(d[3:0]);
  endfunction

  function automatic logic [W:0] bcd_addsub(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic sub);
    logic [W:0] r;
    logic       c;
    logic [4:0] t;
    r = '0;
    c = 1'b0;
    for (int i = 0; i < DIGITS; i++) begin
      if (sub) begin
        t = {1'b0, a[4*i +: 4]} - {1'b0, b[4*i +: 4]} - {4'b0, c};
        c = t[4];
        if (c) t = t + 5'd10;
      end else begin
        t = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, c};
        c = (t > 5'd9);
        if (c) t = t - 5'd10;
      end
      r[4*i +: 4] = t[3:0];
    end
    r[W] = c;
    return r;
  endfunction

  logic [3:0]   op;
  logic [7:0]   xx;
  logic [W-1:0] opnd;
  logic [W:0]   res;
  logic [7:0]   pc_inc;
  logic         exec;

  assign op     = ir[W-1 -: 4];
  assign xx     = ir[7:0];
  assign opnd   = mem[slot(xx)];
  assign res    = bcd_addsub(acc, opnd, op == 4'd2);
  assign pc_inc = (pc[3:0] == 4'd9) ? {((pc[7:4] == 4'd9) ? 4'd0 : pc[7:4] + 4'd1), 4'd0}
                                    : {pc[7:4], pc[3:0] + 4'd1};
  assign exec      = (st == S_EXEC);
  assign in_ready  = exec && (ir == W'(12'h901));
  assign out_valid = exec && (ir == W'(12'h902));
  assign calc_out  = acc;
  assign calc_neg  = neg;
  assign halted    = (st == S_HALT);

  always_ff @(posedge clk) begin
    if (ld_we)
      mem[slot(ld_addr)] <= ld_data;
    else if (rst_n && exec && op == 4'd3)
      mem[slot(xx)] <= acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_FETCH;
      pc  <= '0;
      ir  <= '0;
      acc <= '0;
      neg <= 1'b0;
    end else begin
      case (st)
        S_FETCH: begin
          ir <= mem[slot(pc)];
          pc <= pc_inc;
          st <= S_EXEC;
        end
        S_EXEC: begin
          st <= S_FETCH;
          case (op)
            4'd0: if (xx == 8'h00) st <= S_HALT;
            4'd1: begin
              acc <= res[W-1:0];
              if (res[W]) neg <= 1'b0;
            end
            4'd2: begin
              acc <= res[W-1:0];
              neg <= res[W];
            end
            4'd5: begin
              acc <= opnd;
              neg <= 1'b0;
            end
            4'd6: pc <= xx;
            4'd7: if (acc == '0) pc <= xx;
            4'd8: if (!neg) pc <= xx;
            4'd9: if (xx == 8'h01) begin
              if (in_valid) begin
                acc <= in_data;
                neg <= 1'b0;
              end else begin
                st <= S_EXEC;
              end
            end
            default: ;
          endcase
        end
        S_HALT: ;
        default: st <= S_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/bcd_mailbox_cpu_chk.sv
`timescale 1ns/1ps
module bcd_mailbox_cpu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [11:0] in_data,
  input logic        in_ready,
  input logic        out_valid,
  input logic [11:0] calc_out,
  input logic        calc_neg,
  input logic        halted
);
  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && in_valid |=> (calc_out == $past(in_data)) && !calc_neg);

  a_r8_wait: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> in_ready && $stable(calc_out));

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(calc_out) && $stable(calc_neg));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !in_ready && !out_valid);

  a_r3_bcd_digits: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_out[3:0] <= 4'd9) && (calc_out[7:4] <= 4'd9) && (calc_out[11:8] <= 4'd9));
endmodule

bind bcd_mailbox_cpu bcd_mailbox_cpu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_valid(out_valid), .calc_out(calc_out),
  .calc_neg(calc_neg), .halted(halted)
);

// File: tb/test_bcd_mailbox_cpu.sv
`timescale 1ns/1ps
module test_bcd_mailbox_cpu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_we = 1'b0;
  logic [7:0] ld_addr = '0;
  logic [11:0] ld_data = '0;
  logic in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic in_ready, out_valid, calc_neg, halted;
  logic [11:0] calc_out;

  always #2.5 clk = ~clk;

  bcd_mailbox_cpu i_bcd_mailbox_cpu (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .calc_out(calc_out), .calc_neg(calc_neg), .halted(halted)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  bit live = 0;
  int mmem [100];
  int mpc = 0, macc = 0, mneg = 0, mst = 0, mir = 0;
  int inq [$];
  int outs [$];

  function automatic logic [11:0] tobcd(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic int frombcd(input logic [11:0] v);
    return int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    ld_we    = 1'b0;
    in_valid = (inq.size() > 0) && (cyc % 3 != 1);
    in_data  = (inq.size() > 0) ? tobcd(inq[0]) : 12'h0;
  endtask

  task automatic poke(input int a, input int v);
    tick();
    ld_we   = 1'b1;
    ld_addr = tobcd(a)[7:0];
    ld_data = tobcd(v);
  endtask

  always @(posedge clk) begin
    int op, a, s, wa, wv;
    bit wr;
    wr = 0; wa = 0; wv = 0;
    if (!rst_n) begin
      mst = 0; mpc = 0; macc = 0; mneg = 0; mir = 0;
    end else begin
      case (mst)
        0: begin mir = mmem[mpc]; mpc = (mpc + 1) % 100; mst = 1; end
        1: begin
          op = mir / 100; a = mir % 100; mst = 0;
          case (op)
            0: if (a == 0) mst = 2;
            1: begin s = macc + mmem[a]; if (s >= 1000) begin s -= 1000; mneg = 0; end macc = s; end
            2: begin s = macc - mmem[a]; if (s < 0) begin s += 1000; mneg = 1; end else mneg = 0; macc = s; end
            3: begin wr = 1; wa = a; wv = macc; end
            5: begin macc = mmem[a]; mneg = 0; end
            6: mpc = a;
            7: if (macc == 0) mpc = a;
            8: if (mneg == 0) mpc = a;
            9: if (a == 1) begin
                 if (in_valid) begin macc = inq.pop_front(); mneg = 0; end
                 else mst = 1;
               end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    if (wr) mmem[wa] = wv;
    if (ld_we) mmem[frombcd({4'h0, ld_addr})] = frombcd(ld_data);
  end

  always @(negedge clk) begin
    if (live) begin
      chk("R3 R4 R5 calc_out", int'(calc_out), int'(tobcd(macc)));
      chk("R6 calc_neg", int'(calc_neg), mneg);
      chk("R8 in_ready", int'(in_ready), int'(mst == 1 && mir == 901));
      chk("R9 out_valid", int'(out_valid), int'(mst == 1 && mir == 902));
      chk("R10 halted", int'(halted), int'(mst == 2));
      if (out_valid) outs.push_back(frombcd(calc_out));
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic run_to_halt();
    for (int n = 0; n < 1000 && !halted; n++) tick();
    chk("R10 reached halt", int'(halted), 1);
  endtask

  initial begin
    int exp_a [5] = '{998, 5, 128, 0, 593};
    for (int i = 0; i < 100; i++) poke(i, 0);
    poke(0, 901); poke(1, 250); poke(2, 902); poke(3, 811); poke(4, 150);
    poke(5, 902); poke(6, 812); poke(7, 0);   poke(11, 0);  poke(12, 351);
    poke(13, 552); poke(14, 151); poke(15, 902); poke(16, 253); poke(17, 720);
    poke(18, 0);  poke(20, 430); poke(21, 905); poke(22, 15);  poke(23, 698);
    poke(98, 902); poke(99, 901);
    poke(50, 7); poke(52, 123); poke(53, 128);
    tick();
    chk("R1 calc_out", int'(calc_out), 0);
    chk("R1 calc_neg", int'(calc_neg), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 strobes", int'(in_ready) + int'(out_valid), 0);
    live = 1;
    inq = '{5, 42, 600};
    tick();
    rst_n = 1'b1;
    run_to_halt();
    chk("R2 R7 R11 output count", outs.size(), 5);
    for (int i = 0; i < 5; i++)
      chk("R3 R4 R5 R7 output value", (i < outs.size()) ? outs[i] : -1, exp_a[i]);
    chk("R8 inputs consumed", inq.size(), 0);
    for (int i = 0; i < 12; i++) tick();
    chk("R10 still halted", int'(halted), 1);
    chk("R10 no strobe after halt", outs.size(), 5);

    rst_n = 1'b0;
    outs.delete();
    poke(0, 560); poke(1, 902); poke(2, 705); poke(3, 600); poke(5, 0);
    poke(60, 250);
    tick();
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) tick();
    poke(60, 0);
    tick();
    run_to_halt();
    chk("R12 first output", (outs.size() > 0) ? outs[0] : -1, 250);
    chk("R12 R7 last output", (outs.size() > 0) ? outs[outs.size() - 1] : -1, 0);
    chk("R7 loop repeated", int'(outs.size() > 3), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule